// File: doc/BRIEF.md
# Multi-Stage Conversion Sequence Scheduler

This block paces a converter that measures a programmable number of input stages one after another. Each group of stages forms a sequence. The block counts the stages and their durations, marks the start and end of each stage and of each sequence, and captures a 16-bit data word into a result register whenever a stage ends. Time is measured in ticks of a tick-enable input. One decimation sample lasts `SAMPLE_TICKS` ticks, and a stage lasts 64, 128 or 256 samples.

Two modes are available. In full-power mode the sequences follow each other with no gap. In low-power mode each sequence is followed by a sleep interval of one to four delay steps, chosen by a 2-bit code. The busy flag is low during that interval. The stage count, decimation, mode and delay code are read only when a sequence begins.

Top module: `conv_seq_scheduler`

## Requirements
- R1: After reset all strobes, `busy`, `stageIdx` and `result` are zero. The block stays idle while `enable` is low.
- R2: A sequence holds `lastStage`+1 stages. Any value above 11 is treated as 11, which gives twelve stages.
- R3: A stage lasts `SAMPLE_TICKS`×64×m ticks. The multiplier m is 1 when `decimSel`=00, 2 when it is 01, and 4 when it is 10 or 11. With `decimSel`=01 and `lastStage`=5, one sequence lasts 768×`SAMPLE_TICKS` ticks.
- R4: In full-power mode (`lowPower`=0) with `enable` high, the next sequence starts in the cycle in which the previous one reports completion.
- R5: In low-power mode (`lowPower`=1) the block sleeps after each sequence for (`delayCode`+1)×`DELAY_STEP_TICKS` ticks with `busy` low, then starts again. Codes 00, 01, 10 and 11 give 1, 2, 3 and 4 steps.
- R6: The configuration inputs are sampled only when a sequence starts. A change made during a sequence has no effect until the next one.
- R7: At every stage end, `result` loads `dataIn` as it was at that clock edge. At all other times `result` holds its value.
- R8: `stageIdx` counts from 0 to the last stage. `stageStart` pulses for one cycle each time a stage is entered.
- R9: `stageDone` pulses for one cycle at every stage end. `seqDone` pulses only together with the `stageDone` of the final stage.
- R10: A clock edge with `tickEn` low does not advance the stage timer or the sleep timer.
- R11: If `enable` falls during a sequence, that sequence completes and the block then goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new sequences to start |
| tickEn | input | 1 | Time base; each high cycle is one tick |
| lastStage | input | 4 | Index of the final stage in a sequence |
| decimSel | input | 2 | Decimation select |
| lowPower | input | 1 | 1 selects low-power mode with sleep |
| delayCode | input | 2 | Sleep length code |
| dataIn | input | 16 | Conversion word captured at stage end |
| stageIdx | output | 4 | Current stage index |
| stageStart | output | 1 | Stage-entry strobe |
| stageDone | output | 1 | Stage-end strobe |
| seqDone | output | 1 | Sequence-end strobe |
| busy | output | 1 | High while a sequence is converting |
| result | output | 16 | Last captured conversion word |

## Verification
The assertions assume that `tickEn` is the only source of timing. They also assume that the configuration inputs are stable at each clock edge, though they may change between any two edges, including in the middle of a sequence. The bench drives every input on the falling edge. It changes the configuration in the middle of sequences, switches `tickEn` to a gapped pattern, and lowers `enable` partway through a sequence, all within those assumptions.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_SLEEP = 2'd2
  } seqState_e;

  // strobes issued by the control to the datapath, one cycle each
  typedef struct packed {
    logic loadCfg;
    logic tickInc;
    logic stageEnd;
    logic nextStage;
    logic delayClr;
    logic delayInc;
  } dpCmd_t;

  // log2 of the decimation multiplier relative to 64
  function automatic logic [1:0] decimShift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/conv_seq_datapath.sv
module conv_seq_datapath
  import conv_seq_pkg::*;
#(
  parameter int SAMPLE_TICKS     = 12,
  parameter int DELAY_STEP_TICKS = 200000,
  parameter int STAGE_W          = 4,
  parameter int NUM_STAGES       = 12,
  parameter int DATA_W           = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic [STAGE_W-1:0] lastStageIn,
  input  logic [1:0]         decimSelIn,
  input  logic               lowPowerIn,
  input  logic [1:0]         delayCodeIn,
  input  logic [DATA_W-1:0]  dataIn,
  output logic               tickLast,
  output logic               stageLast,
  output logic               delayLast,
  output logic               lpCfg,
  output logic [STAGE_W-1:0] stageIdx,
  output logic [DATA_W-1:0]  result
);

  localparam int TICK_W = $clog2(SAMPLE_TICKS * 256 + 1);
  localparam int DLY_W  = $clog2(DELAY_STEP_TICKS * 4 + 1);
  localparam logic [STAGE_W-1:0] MAX_LAST = STAGE_W'(NUM_STAGES - 1);

  logic [STAGE_W-1:0] lastCfg;
  logic [1:0]         decimCfg;
  logic [1:0]         delayCfg;
  logic [TICK_W-1:0]  tickCnt;
  logic [DLY_W-1:0]   dlyCnt;
  logic [TICK_W-1:0]  lenTab [4];
  logic [DLY_W-1:0]   dlyTab [4];
  logic [STAGE_W-1:0] lastClamped;

  // per-code stage and sleep lengths
  for (genvar g = 0; g < 4; g++) begin : g_tab
    assign lenTab[g] = TICK_W'(SAMPLE_TICKS * 64) << decimShift(2'(g));
    assign dlyTab[g] = DLY_W'(DELAY_STEP_TICKS * (g + 1));
  end

  assign lastClamped = (lastStageIn > MAX_LAST) ? MAX_LAST : lastStageIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCfg  <= '0;
      decimCfg <= '0;
      lpCfg    <= 1'b0;
      delayCfg <= '0;
    end else if (cmd.loadCfg) begin
      lastCfg  <= lastClamped;
      decimCfg <= decimSelIn;
      lpCfg    <= lowPowerIn;
      delayCfg <= delayCodeIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (cmd.loadCfg || cmd.stageEnd) begin
      tickCnt <= '0;
    end else if (cmd.tickInc) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageIdx <= '0;
    end else if (cmd.loadCfg) begin
      stageIdx <= '0;
    end else if (cmd.nextStage) begin
      stageIdx <= stageIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dlyCnt <= '0;
    end else if (cmd.delayClr) begin
      dlyCnt <= '0;
    end else if (cmd.delayInc) begin
      dlyCnt <= dlyCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
    end else if (cmd.stageEnd) begin
      result <= dataIn;
    end
  end

  assign tickLast  = (tickCnt == lenTab[decimCfg] - 1'b1);
  assign stageLast = (stageIdx == lastCfg);
  assign delayLast = (dlyCnt == dlyTab[delayCfg] - 1'b1);

  // R2: the stage index never passes the clamped maximum
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    stageIdx <= MAX_LAST);

  // R3: the stage timer stays inside the selected stage length
  p_tick_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt < lenTab[decimCfg]);

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
  import conv_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   tickEn,
  input  logic   tickLast,
  input  logic   stageLast,
  input  logic   delayLast,
  input  logic   lpCfg,
  output dpCmd_t cmd,
  output logic   stageStart,
  output logic   stageDone,
  output logic   seqDone,
  output logic   busy
);

  seqState_e state, stateNxt;
  logic startNxt, doneNxt, seqNxt;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    startNxt = 1'b0;
    doneNxt  = 1'b0;
    seqNxt   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (enable) begin
          cmd.loadCfg = 1'b1;
          startNxt    = 1'b1;
          stateNxt    = S_RUN;
        end
      end
      S_RUN: begin
        if (tickEn) begin
          if (tickLast) begin
            cmd.stageEnd = 1'b1;
            doneNxt      = 1'b1;
            if (stageLast) begin
              seqNxt = 1'b1;
              if (lpCfg) begin
                cmd.delayClr = 1'b1;
                stateNxt     = S_SLEEP;
              end else if (enable) begin
                cmd.loadCfg = 1'b1;
                startNxt    = 1'b1;
              end else begin
                stateNxt = S_IDLE;
              end
            end else begin
              cmd.nextStage = 1'b1;
              startNxt      = 1'b1;
            end
          end else begin
            cmd.tickInc = 1'b1;
          end
        end
      end
      S_SLEEP: begin
        if (tickEn) begin
          if (delayLast) begin
            if (enable) begin
              cmd.loadCfg = 1'b1;
              startNxt    = 1'b1;
              stateNxt    = S_RUN;
            end else begin
              stateNxt = S_IDLE;
            end
          end else begin
            cmd.delayInc = 1'b1;
          end
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      stageStart <= 1'b0;
      stageDone  <= 1'b0;
      seqDone    <= 1'b0;
    end else begin
      state      <= stateNxt;
      stageStart <= startNxt;
      stageDone  <= doneNxt;
      seqDone    <= seqNxt;
    end
  end

  assign busy = (state == S_RUN);

  // R9: a sequence end is always also a stage end
  p_seq_with_stage_r9: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> stageDone);

  // R4: still converting after a sequence end means a new one has begun
  p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && busy) |-> stageStart);

endmodule

// File: rtl/conv_seq_scheduler.sv
module conv_seq_scheduler
  import conv_seq_pkg::*;
#(
  parameter int SAMPLE_TICKS     = 12,
  parameter int DELAY_STEP_TICKS = 200000,
  parameter int NUM_STAGES       = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        tickEn,
  input  logic [3:0]  lastStage,
  input  logic [1:0]  decimSel,
  input  logic        lowPower,
  input  logic [1:0]  delayCode,
  input  logic [15:0] dataIn,
  output logic [3:0]  stageIdx,
  output logic        stageStart,
  output logic        stageDone,
  output logic        seqDone,
  output logic        busy,
  output logic [15:0] result
);

  dpCmd_t cmd;
  logic   tickLast, stageLast, delayLast, lpCfg;

  conv_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .tickEn     (tickEn),
    .tickLast   (tickLast),
    .stageLast  (stageLast),
    .delayLast  (delayLast),
    .lpCfg      (lpCfg),
    .cmd        (cmd),
    .stageStart (stageStart),
    .stageDone  (stageDone),
    .seqDone    (seqDone),
    .busy       (busy)
  );

  conv_seq_datapath #(
    .SAMPLE_TICKS     (SAMPLE_TICKS),
    .DELAY_STEP_TICKS (DELAY_STEP_TICKS),
    .STAGE_W          (4),
    .NUM_STAGES       (NUM_STAGES),
    .DATA_W           (16)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .lastStageIn (lastStage),
    .decimSelIn  (decimSel),
    .lowPowerIn  (lowPower),
    .delayCodeIn (delayCode),
    .dataIn      (dataIn),
    .tickLast    (tickLast),
    .stageLast   (stageLast),
    .delayLast   (delayLast),
    .lpCfg       (lpCfg),
    .stageIdx    (stageIdx),
    .result      (result)
  );

  // R7: the result register moves only with a stage-end strobe
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !stageDone |-> $stable(result));

  // R10: a converting cycle with no tick leaves the stage index alone
  p_tick_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tickEn) |=> $stable(stageIdx));

  // R8: each stage entry either restarts at zero or steps by one
  p_idx_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    stageStart |-> (stageIdx == 4'd0 || stageIdx == 4'($past(stageIdx) + 1)));

endmodule

// File: tb/conv_seq_scheduler_bench.sv
module conv_seq_scheduler_bench;

  localparam int ST = 1;
  localparam int DS = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0, enable = 1'b0, tickEn = 1'b1, lowPower = 1'b0;
  logic [3:0]  lastStage = '0;
  logic [1:0]  decimSel = '0, delayCode = '0;
  logic [15:0] dataIn = 16'h0101;
  logic [3:0]  stageIdx;
  logic        stageStart, stageDone, seqDone, busy;
  logic [15:0] result;

  conv_seq_scheduler #(.SAMPLE_TICKS(ST), .DELAY_STEP_TICKS(DS)) u_conv_seq_scheduler (
    .clk(clk), .rstN(rstN), .enable(enable), .tickEn(tickEn),
    .lastStage(lastStage), .decimSel(decimSel), .lowPower(lowPower),
    .delayCode(delayCode), .dataIn(dataIn), .stageIdx(stageIdx),
    .stageStart(stageStart), .stageDone(stageDone), .seqDone(seqDone),
    .busy(busy), .result(result)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit gapMode = 0, cmpOn = 0, ended = 0;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  task automatic finishRun();
    ended = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // behavioural reference: integer countdowns per mode
  int mMode = 0, mRem = 0, mDrem = 0, mStage = 0, mCount = 0, mLen = 0, mLp = 0, mCode = 0;
  int eStart = 0, eDone = 0, eSeq = 0;
  logic [15:0] mRes = '0;

  function automatic void beginSeq();
    int mult;
    mult   = (decimSel == 2'd0) ? 1 : (decimSel == 2'd1) ? 2 : 4;
    mCount = ((lastStage > 4'd11) ? 11 : int'(lastStage)) + 1;
    mLen   = 64 * mult * ST;
    mLp    = int'(lowPower);
    mCode  = int'(delayCode);
    mStage = 0;
    mRem   = mLen;
    mMode  = 1;
    eStart = 1;
  endfunction

  always @(posedge clk) begin
    cyc++;
    eStart = 0; eDone = 0; eSeq = 0;
    if (!rstN) begin
      mMode = 0; mStage = 0; mRes = '0;
    end else begin
      case (mMode)
        0: if (enable) beginSeq();
        1: if (tickEn) begin
             if (mRem == 1) begin
               eDone = 1;
               mRes  = dataIn;
               if (mStage == mCount - 1) begin
                 eSeq = 1;
                 if (mLp != 0) begin mMode = 2; mDrem = (mCode + 1) * DS; end
                 else if (enable) beginSeq();
                 else mMode = 0;
               end else begin
                 mStage++; mRem = mLen; eStart = 1;
               end
             end else mRem--;
           end
        default: if (tickEn) begin
             if (mDrem == 1) begin
               if (enable) beginSeq(); else mMode = 0;
             end else mDrem--;
           end
      endcase
    end
    if (cyc > 150000 && !ended) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finishRun();
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R8 stageIdx", int'(stageIdx), mStage);
      chk("R8 stageStart", int'(stageStart), eStart);
      chk("R9 stageDone", int'(stageDone), eDone);
      chk("R9 seqDone", int'(seqDone), eSeq);
      chk("R5 busy", int'(busy), (mMode == 1) ? 1 : 0);
      chk("R7 result", int'(result), int'(mRes));
    end
  end

  // free-running stimulus for data and tick gating
  always @(negedge clk) begin
    dataIn <= dataIn + 16'h1357;
    tickEn <= gapMode ? ((cyc % 3) != 0) : 1'b1;
  end

  task automatic waitStart();
    do @(negedge clk); while (!(stageStart && stageIdx == 4'd0));
  endtask

  task automatic countToStart(output int p);
    p = 0;
    do begin @(negedge clk); p++; end while (!(stageStart && stageIdx == 4'd0));
  endtask

  task automatic period(output int p);
    waitStart();
    countToStart(p);
  endtask

  initial begin
    int p;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    cmpOn = 1;
    repeat (2) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset stageIdx", int'(stageIdx), 0);
    repeat (10) @(negedge clk);
    chk("R1 idle without enable", int'(busy), 0);

    // full-power worked example: decim 128, field 5
    lastStage = 4'd5; decimSel = 2'd1; enable = 1'b1;
    period(p);
    chk("R3 decim128 six stages", p, 768 * ST);

    lastStage = 4'd0; decimSel = 2'd0;
    period(p);
    chk("R2 single stage", p, 64 * ST);

    lastStage = 4'd1; decimSel = 2'd2;
    period(p);
    chk("R3 decim256", p, 512 * ST);

    decimSel = 2'd3;
    period(p);
    chk("R3 code 11 as 256", p, 512 * ST);

    lastStage = 4'd15; decimSel = 2'd0;
    period(p);
    chk("R2 clamp to twelve", p, 768 * ST);

    // mid-sequence change takes effect only at the next start
    lastStage = 4'd2;
    waitStart();
    repeat (10) @(negedge clk);
    lastStage = 4'd0;
    countToStart(p);
    chk("R6 mid-sequence change ignored", p + 10, 192 * ST);
    countToStart(p);
    chk("R6 change applied next", p, 64 * ST);

    // low-power wake-up
    lowPower = 1'b1; delayCode = 2'd1;
    period(p);
    chk("R5 delay code 01", p, 64 * ST + 2 * DS);
    delayCode = 2'd3;
    period(p);
    chk("R5 delay code 11", p, 64 * ST + 4 * DS);
    delayCode = 2'd0;
    period(p);
    chk("R5 delay code 00", p, 64 * ST + DS);

    // gapped ticks stretch the sequence
    lowPower = 1'b0; gapMode = 1;
    period(p);
    chk("R10 gaps lengthen period", int'(p > 64 * ST), 1);
    gapMode = 0;
    period(p);
    chk("R4 back to back", p, 64 * ST);

    // enable falls mid-sequence
    waitStart();
    repeat (5) @(negedge clk);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    chk("R11 still finishing", int'(busy), 1);
    repeat (200) @(negedge clk);
    chk("R11 idle after finish", int'(busy), 0);
    finishRun();
  end

endmodule